// File: doc/BRIEF.md
# Double-word access splitter

This block carries out one 64-bit floating-point load or store over a memory port that is only 32 bits wide. A request brings a base address, a signed 16-bit displacement and, for a store, 64 bits of data. The block adds the base and the sign-extended displacement to form the effective address. It checks that this address lies on an 8-byte boundary. It then runs two word transactions one after the other: the first at the effective address and the second four bytes above it.

The byte order in force for the operation is the configured big-endian setting XORed with a reverse-endian control bit. The block samples both bits when it accepts the request. This order decides which 32-bit half of the store data goes out in the first write. For a load, it decides which half of the 64-bit result each returned word fills. A misaligned address produces a one-cycle fault pulse that carries the address, and no memory transaction is started.

Control is a single state machine with these states:
- S_IDLE: waiting for a request.
- S_ADDR0: issuing the first word request. It moves to S_WAIT0 when the memory accepts.
- S_WAIT0: waiting for the first response. It moves to S_ADDR1 when the response arrives.
- S_ADDR1: issuing the second word request. It moves to S_WAIT1 when the memory accepts.
- S_WAIT1: waiting for the second response. It moves to S_DONE when the response arrives.
- S_DONE: one cycle with the completion pulse, then back to S_IDLE.
- S_FAULT: one cycle with the fault pulse, then back to S_IDLE.

From S_IDLE, an accepted request goes to S_FAULT if the address is misaligned, and to S_ADDR0 otherwise.

Top module: `dw_split`

## Requirements
- R1: The effective address is req_base plus req_offset sign-extended to the address width, computed modulo 2^ADDR_W.
- R2: If bits 2:0 of the effective address are not all zero, fault is high for exactly the one cycle after acceptance. In that cycle fault_addr carries the effective address. No memory request is raised for the operation. This applies to loads and to stores.
- R3: An aligned operation makes exactly two word requests. The first is at the effective address and the second at the effective address plus 4. mem_we is 1 on both for a store and 0 on both for a load.
- R4: The active order is big-endian when big_endian_cfg XOR reverse_endian is 1, and little-endian otherwise. Both bits are sampled in the cycle the request is accepted; later changes have no effect on that operation.
- R5: For a load in big-endian order, the first returned word becomes ld_data[63:32] and the second becomes ld_data[31:0]. In little-endian order the first word becomes ld_data[31:0] and the second becomes ld_data[63:32].
- R6: For a store in big-endian order, the first write carries req_wdata[63:32] and the second carries req_wdata[31:0]. In little-endian order the first write carries req_wdata[31:0] and the second carries req_wdata[63:32].
- R7: req_ready is high only in S_IDLE. A request is accepted on a clock edge where both req_valid and req_ready are high. busy is high from the cycle after acceptance up to and including the cycle of the completion or fault pulse.
- R8: While mem_req_valid is high and mem_req_ready is low, the request and its address and data stay unchanged. The second request is not raised until the response to the first has been received. A response is expected on any cycle after the one in which its request was accepted.
- R9: After a load's second response, ld_valid is high for exactly one cycle, and ld_data holds the assembled value in that cycle. After a store's second response, st_done is high for exactly one cycle. The two pulses never occur together.
- R10: A synchronous active-high reset returns the block to S_IDLE. It clears ld_data, including any half already captured, and drops mem_req_valid, busy and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_cfg | input | 1 | Configured byte order, 1 means big-endian |
| reverse_endian | input | 1 | Inverts the configured byte order |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Block can accept an operation |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_base | input | ADDR_W | Base address value |
| req_offset | input | OFF_W | Signed displacement |
| req_wdata | input | 2*WORD_W | Store data |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Word request valid |
| mem_req_ready | input | 1 | Memory accepts the word request |
| mem_addr | output | ADDR_W | Word request address |
| mem_we | output | 1 | Word request is a write |
| mem_wdata | output | WORD_W | Word write data |
| mem_rsp_valid | input | 1 | Word response valid |
| mem_rsp_rdata | input | WORD_W | Word read data |
| ld_valid | output | 1 | Load result pulse |
| ld_data | output | 2*WORD_W | Assembled load result |
| st_done | output | 1 | Store completion pulse |
| fault | output | 1 | Alignment fault pulse |
| fault_addr | output | ADDR_W | Faulting effective address |

## Verification
The completion pulse (ld_valid or st_done) and readiness for the next request fall on neighbouring cycles. The risk is that a design lets them overlap, reopening the request port while the result is still being signalled. In every completion cycle the bench requires req_ready low and busy high. On the next cycle it requires req_ready high and the pulse gone. The same cycle-by-cycle rule is applied to the fault pulse, which must never coincide with a memory request. The byte-order inputs are inverted right after acceptance to show that the sampled order governs both word placement and write order.

// File: rtl/dws_pkg.sv
package dws_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR0,
        S_WAIT0,
        S_ADDR1,
        S_WAIT1,
        S_DONE,
        S_FAULT
    } dws_state_e;
endpackage

// File: rtl/dws_addr_gen.sv
module dws_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int ALIGN_BITS = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] offset_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_noext
            assign offset_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    assign eff_addr   = base + offset_ext;
    assign misaligned = |eff_addr[ALIGN_BITS-1:0];
endmodule

// File: rtl/dws_store_lane.sv
module dws_store_lane #(
    parameter int WORD_W = 32
) (
    input  logic [2*WORD_W-1:0] data,
    input  logic                big,
    input  logic                second,
    output logic [WORD_W-1:0]   word
);
    logic take_hi;

    // Big-endian sends the upper half first; little-endian sends it second.
    assign take_hi = big ^ second;
    assign word    = take_hi ? data[2*WORD_W-1:WORD_W] : data[WORD_W-1:0];
endmodule

// File: rtl/dws_load_asm.sv
module dws_load_asm #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                capture,
    input  logic                big,
    input  logic                second,
    input  logic [WORD_W-1:0]   word,
    output logic [2*WORD_W-1:0] data
);
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] lo_q;
    logic              to_hi;

    assign to_hi = big ^ second;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (capture) begin
            if (to_hi) begin
                hi_q <= word;
            end else begin
                lo_q <= word;
            end
        end
    end

    assign data = {hi_q, lo_q};
endmodule

// File: rtl/dw_split.sv
module dw_split
    import dws_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int WORD_W     = 32,
    parameter int ALIGN_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                big_endian_cfg,
    input  logic                reverse_endian,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [2*WORD_W-1:0] req_wdata,
    output logic                busy,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_rdata,
    output logic                ld_valid,
    output logic [2*WORD_W-1:0] ld_data,
    output logic                st_done,
    output logic                fault,
    output logic [ADDR_W-1:0]   fault_addr
);
    localparam int          DW       = 2 * WORD_W;
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_W / 8);

    dws_state_e state_q, state_d;

    logic [ADDR_W-1:0] ea_d;
    logic              mis_d;
    logic [ADDR_W-1:0] ea_q;
    logic              store_q;
    logic              big_q;
    logic [DW-1:0]     wdata_q;
    logic              accept;
    logic              second;
    logic              capture;
    logic [WORD_W-1:0] lane_word;

    dws_addr_gen #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .ALIGN_BITS(ALIGN_BITS)
    ) i_addr (
        .base      (req_base),
        .offset    (req_offset),
        .eff_addr  (ea_d),
        .misaligned(mis_d)
    );

    assign accept  = req_valid && (state_q == S_IDLE);
    assign second  = (state_q == S_ADDR1) || (state_q == S_WAIT1);
    assign capture = mem_rsp_valid && !store_q &&
                     ((state_q == S_WAIT0) || (state_q == S_WAIT1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = mis_d ? S_FAULT : S_ADDR0;
            S_ADDR0: if (mem_req_ready) state_d = S_WAIT0;
            S_WAIT0: if (mem_rsp_valid) state_d = S_ADDR1;
            S_ADDR1: if (mem_req_ready) state_d = S_WAIT1;
            S_WAIT1: if (mem_rsp_valid) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Operation context captured at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q    <= '0;
            store_q <= 1'b0;
            big_q   <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            ea_q    <= ea_d;
            store_q <= req_store;
            big_q   <= big_endian_cfg ^ reverse_endian;
            wdata_q <= req_wdata;
        end
    end

    dws_store_lane #(
        .WORD_W(WORD_W)
    ) i_lane (
        .data  (wdata_q),
        .big   (big_q),
        .second(second),
        .word  (lane_word)
    );

    dws_load_asm #(
        .WORD_W(WORD_W)
    ) i_asm (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .capture(capture),
        .big    (big_q),
        .second (second),
        .word   (mem_rsp_rdata),
        .data   (ld_data)
    );

    // Output logic
    always_comb begin
        req_ready     = 1'b0;
        busy          = 1'b1;
        mem_req_valid = 1'b0;
        mem_addr      = '0;
        mem_we        = 1'b0;
        mem_wdata     = '0;
        ld_valid      = 1'b0;
        st_done       = 1'b0;
        fault         = 1'b0;
        fault_addr    = '0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            S_ADDR0, S_ADDR1: begin
                mem_req_valid = 1'b1;
                mem_addr      = second ? (ea_q + WORD_STEP) : ea_q;
                mem_we        = store_q;
                mem_wdata     = store_q ? lane_word : '0;
            end
            S_WAIT0, S_WAIT1: begin
            end
            S_DONE: begin
                ld_valid = !store_q;
                st_done  = store_q;
            end
            S_FAULT: begin
                fault      = 1'b1;
                fault_addr = ea_q;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_rsp_valid,
    input logic              ld_valid,
    input logic              st_done,
    input logic              fault,
    input logic [ADDR_W-1:0] fault_addr
);
    logic              outstanding_q;
    logic              word_odd_q;
    logic [ADDR_W-1:0] first_addr_q;
    logic              mem_hs;

    assign mem_hs = mem_req_valid && mem_req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
            word_odd_q    <= 1'b0;
            first_addr_q  <= '0;
        end else begin
            if (mem_hs) begin
                outstanding_q <= 1'b1;
                word_odd_q    <= !word_odd_q;
                if (!word_odd_q) first_addr_q <= mem_addr;
            end else if (mem_rsp_valid) begin
                outstanding_q <= 1'b0;
            end
        end
    end

    a_r2_fault_no_mem: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_req_valid && (fault_addr[2:0] != 3'b000)));

    a_r2_fault_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    a_r3_second_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_hs && word_odd_q) |-> (mem_addr == first_addr_q + ADDR_W'(4)));

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !busy);

    a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata)));

    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        outstanding_q |-> !mem_req_valid);

    a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({ld_valid, st_done, fault}) <= 1);

    a_r9_ld_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !ld_valid);

    a_r9_st_one_cycle: assert property (@(posedge clk) disable iff (rst)
        st_done |=> !st_done);
endmodule

bind dw_split dws_checker #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
) i_dws_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .ld_valid     (ld_valid),
    .st_done      (st_done),
    .fault        (fault),
    .fault_addr   (fault_addr)
);

// File: tb/test_dw_split.sv
`timescale 1ns/1ps
module test_dw_split;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        big_endian_cfg = 1'b0;
    logic        reverse_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [63:0] req_wdata = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        ld_valid;
    logic [63:0] ld_data;
    logic        st_done;
    logic        fault;
    logic [31:0] fault_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int cycle    = 0;
    bit finished = 0;

    // memory model state
    int          bfm_stall = 0;
    int          bfm_lat   = 0;
    int          bfm_wait  = 0;
    int          bfm_cnt   = 0;
    bit          bfm_pend  = 0;
    logic [31:0] bfm_paddr = '0;
    int          log_n     = 0;
    logic [31:0] log_addr [4];
    logic        log_we   [4];
    logic [31:0] log_data [4];

    dw_split i_dw_split (
        .clk(clk), .rst(rst),
        .big_endian_cfg(big_endian_cfg), .reverse_endian(reverse_endian),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .st_done(st_done),
        .fault(fault), .fault_addr(fault_addr)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cycle <= cycle + 1;

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        wait (cycle >= 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycle);
        finish_run();
    end

    // Memory responder: acts at falling edges only
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rst) begin
                bfm_pend = 0;
                bfm_wait = 0;
                mem_req_ready = 1'b0;
            end else begin
                if (bfm_pend) begin
                    if (bfm_cnt == 0) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_rdata = rd_word(bfm_paddr);
                        bfm_pend = 0;
                    end else begin
                        bfm_cnt--;
                    end
                end
                mem_req_ready = 1'b0;
                if (mem_req_valid && !bfm_pend && !mem_rsp_valid) begin
                    if (bfm_wait < bfm_stall) begin
                        bfm_wait++;
                    end else begin
                        bfm_wait = 0;
                        mem_req_ready = 1'b1;
                        bfm_pend  = 1;
                        bfm_cnt   = bfm_lat;
                        bfm_paddr = mem_addr;
                        if (log_n < 4) begin
                            log_addr[log_n] = mem_addr;
                            log_we[log_n]   = mem_we;
                            log_data[log_n] = mem_wdata;
                        end
                        log_n++;
                    end
                end
            end
        end
    end

    task automatic run_op(input bit st, input logic [31:0] base, input logic [15:0] off,
                          input logic [63:0] wd, input bit cfg, input bit rev,
                          input int stall, input int lat);
        logic [31:0] ea;
        logic        mis;
        logic        big;
        logic [63:0] exp_ld;
        logic [31:0] w_first, w_second;
        int          guard;
        ea  = base + {{16{off[15]}}, off};
        mis = (ea[2:0] != 3'b000);
        big = cfg ^ rev;
        bfm_stall = stall;
        bfm_lat   = lat;
        log_n     = 0;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_base = base; req_offset = off;
        req_wdata = wd; big_endian_cfg = cfg; reverse_endian = rev;
        check(req_ready == 1'b1, "R7", "ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        // flip order inputs after acceptance: R4 says they no longer matter
        big_endian_cfg = ~cfg;
        if (mis) begin
            check(fault == 1'b1 && fault_addr == ea, "R2", "fault pulse/address (R1)",
                  {31'd0, fault, fault_addr}, {31'd1, 1'b1, ea});
            check(busy == 1'b1 && req_ready == 1'b0, "R7", "busy in fault cycle",
                  64'({busy, req_ready}), 64'b10);
            @(negedge clk);
            check(fault == 1'b0 && log_n == 0 && mem_req_valid == 1'b0, "R2",
                  "no memory cycle after fault", 64'(log_n), 64'd0);
        end else begin
            check(fault == 1'b0, "R2", "no fault when aligned", 64'(fault), 64'd0);
            guard = 0;
            while (!(ld_valid || st_done || fault) && guard < 200) begin
                check(busy == 1'b1, "R7", "busy while in flight", 64'(busy), 64'd1);
                @(negedge clk);
                guard++;
            end
            check(log_n == 2, "R3", "two word requests", 64'(log_n), 64'd2);
            check(log_addr[0] == ea && log_addr[1] == ea + 32'd4, "R3", "word addresses (R1)",
                  {log_addr[0], log_addr[1]}, {ea, ea + 32'd4});
            check(log_we[0] == st && log_we[1] == st, "R3", "write enable",
                  64'({log_we[0], log_we[1]}), 64'({st, st}));
            check(ld_valid == !st && st_done == st, "R9", "completion pulse type",
                  64'({ld_valid, st_done}), 64'({!st, st}));
            check(req_ready == 1'b0 && busy == 1'b1, "R7", "not ready in pulse cycle",
                  64'({req_ready, busy}), 64'b01);
            if (st) begin
                w_first  = big ? wd[63:32] : wd[31:0];
                w_second = big ? wd[31:0]  : wd[63:32];
                check(log_data[0] == w_first && log_data[1] == w_second, "R6",
                      "store word order (R4)", {log_data[0], log_data[1]}, {w_first, w_second});
            end else begin
                exp_ld = big ? {rd_word(ea), rd_word(ea + 32'd4)}
                             : {rd_word(ea + 32'd4), rd_word(ea)};
                check(ld_data == exp_ld, "R5", "load assembly (R4)", ld_data, exp_ld);
            end
            @(negedge clk);
            check(ld_valid == 1'b0 && st_done == 1'b0 && req_ready == 1'b1 && busy == 1'b0,
                  "R9", "single-cycle pulse then idle",
                  64'({ld_valid, st_done, req_ready, busy}), 64'b0010);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && busy == 1'b0 && mem_req_valid == 1'b0, "R10",
              "reset state control", 64'({req_ready, busy, mem_req_valid}), 64'b100);
        check(ld_valid == 1'b0 && st_done == 1'b0 && fault == 1'b0 && ld_data == 64'd0,
              "R10", "reset state outputs", ld_data, 64'd0);
        rst = 1'b0;

        for (int e = 0; e < 4; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [2:0]  low3;
                    logic [15:0] off;
                    logic [31:0] base;
                    logic [63:0] wd;
                    low3 = (k % 4 == 3) ? 3'(k / 4 + 1) : 3'd0;
                    off  = {(k >= 8) ? 13'h1FFE : 13'h0021, low3};
                    base = 32'h0000_1000 + 32'(e * 256) + 32'(s * 64) + 32'(k * 8);
                    wd   = {32'hA000_0000 + 32'(k), 32'h0B00_0000 + 32'(e * 16 + s)};
                    run_op(s[0], base, off, wd, e[0], e[1], k % 3, (k / 2) % 3);
                end
            end
        end

        // Address wrap at the top of the address space
        run_op(1'b0, 32'hFFFF_FFF8, 16'h0008, 64'd0, 1'b1, 1'b0, 0, 0);
        run_op(1'b1, 32'h0000_0000, 16'hFFF8, 64'h1122_3344_5566_7788, 1'b0, 1'b0, 1, 1);

        // Reset in the middle of a load after the first word is captured
        bfm_stall = 0;
        bfm_lat   = 0;
        log_n     = 0;
        @(negedge clk);
        req_valid = 1'b1; req_store = 1'b0; req_base = 32'h0000_2000; req_offset = 16'h0010;
        big_endian_cfg = 1'b1; reverse_endian = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(ld_data != 64'd0, "R10", "partial data present before reset", ld_data, 64'd1);
        rst = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && mem_req_valid == 1'b0 && req_ready == 1'b1, "R10",
              "mid-op reset control", 64'({busy, mem_req_valid, req_ready}), 64'b001);
        check(ld_data == 64'd0 && ld_valid == 1'b0, "R10", "mid-op reset clears data",
              ld_data, 64'd0);
        rst = 1'b0;
        run_op(1'b0, 32'h0000_3000, 16'h0000, 64'd0, 1'b0, 1'b1, 2, 2);

        finish_run();
    end
endmodule